// File: doc/BRIEF.md
# NAND Flash Page Program Sequencer

This block is the host-side engine that writes pages into an 8-bit asynchronous NAND flash. A single request carries the operation kind, the column and row of the target page, a byte count and an optional mid-stream column jump. The block then drives chip enable, the command and address latch strobes, the write and read strobes and the data bus. It sends the command, address and data cycles in the order the flash expects, waits for the ready/busy line to return high, reads the status byte and reports pass or fail.

Four operations are supported. A plain page program and a cache program differ only in the confirm byte. An internal data move reads a source page into the die's page register and writes it back to a new row. A bare status poll is also available. The status command depends on the die count parameter: a multi-die target needs the die-addressed status command, which carries a row address. Strobe widths and the settle time after a confirm are parameters counted in system clocks. A programmable limit on busy time ends an operation that never becomes ready.

Top module: `nand_prog_seq`

## Requirements
- R1: In reset and while idle, chip enable, write strobe and read strobe are high, both latch strobes are low, and `busy` and `done` are low.
- R2: Operation code 0 (page program) issues command 80h, then five address bytes in the order column low, column high, row low, row middle, row high. It then issues `req_len` data bytes taken from `wr_data` in stream order, one per `data_take` pulse, and finally the confirm 10h.
- R3: Every write strobe is low for exactly T_WL clocks and every read strobe is low for exactly T_RL clocks. The command latch is high on command cycles only, the address latch on address cycles only, and the two are never high together.
- R4: After any confirm byte (10h, 15h, 35h), no write or read strobe is driven while ready/busy is low. Once it is high again the status command is sent, one status byte is read and `done` pulses for one clock.
- R5: `fail` equals bit 0 of the status byte read at the end of the operation.
- R6: When `req_jump_en` is set, once `req_jump_at` data bytes have been sent the block inserts command 85h and two column bytes of `req_jump_col` (low then high). The rest of the data then follows.
- R7: Operation code 1 (cache program) is the page program sequence with confirm 15h in place of 10h.
- R8: Operation code 2 (internal move) issues 00h, five address bytes of the source row, and 35h. It waits for ready, then issues 85h, five address bytes of `req_dst_row` with the same column, `req_len` data bytes and 10h. Status is then polled with the destination row.
- R9: With NUM_DIES greater than 1 the status command is 78h followed by three row bytes (low, middle, high). With NUM_DIES equal to 1 it is 70h with no address byte.
- R10: If ready/busy stays low for `busy_limit` clocks after the settle time, the operation ends with `timeout` high, `fail` low, a `done` pulse and no status cycle.
- R11: Operation code 3 (status poll) issues only the status command with its address bytes and the status read, and reports `fail` from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start an operation (taken while idle) |
| req_op | input | 2 | 0 program, 1 cache program, 2 internal move, 3 status poll |
| req_col | input | COL_W | Column address |
| req_row | input | ROW_W | Row address (source row for a move) |
| req_dst_row | input | ROW_W | Destination row for a move |
| req_len | input | LEN_W | Number of data bytes |
| req_jump_en | input | 1 | Enable one mid-stream column jump |
| req_jump_at | input | LEN_W | Byte count at which the jump is inserted |
| req_jump_col | input | COL_W | New column after the jump |
| wr_data | input | 8 | Current data byte of the stream |
| data_take | output | 1 | Pulse: `wr_data` is consumed on this clock |
| busy_limit | input | LIM_W | Maximum busy-wait clocks |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock end-of-operation pulse |
| fail | output | 1 | Status FAIL bit of the last operation |
| timeout | output | 1 | Last operation ended on busy time-out |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus data driven by the block |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data from the flash |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
A bus cycle starts the clock after it is issued, and its write strobe rises T_WL clocks later. The bench flash model therefore records each command, address or data byte at the clock where the write strobe goes high. It compares the recorded list against a list built from the request once `done` is seen. `done`, `fail` and `timeout` change together, one clock after the final read strobe has been high for T_RH clocks. They are sampled on the falling edge of that cycle. Strobe widths, the exclusion of the latch strobes and bus silence while busy are compared on every falling clock edge against counters kept in the bench.

// File: rtl/nand_seq_pkg.sv
// Shared types and command codes for the NAND page program sequencer.
package nand_seq_pkg;
    typedef enum logic [1:0] {CYC_CMD, CYC_ADDR, CYC_DIN, CYC_DOUT} cyc_kind_t;
    typedef enum logic [1:0] {OP_PROG = 2'd0, OP_CACHE = 2'd1, OP_MOVE = 2'd2, OP_STAT = 2'd3} op_t;

    localparam logic [7:0] C_LOAD      = 8'h80;
    localparam logic [7:0] C_CONFIRM   = 8'h10;
    localparam logic [7:0] C_CACHE_CF  = 8'h15;
    localparam logic [7:0] C_READ      = 8'h00;
    localparam logic [7:0] C_MOVE_RD   = 8'h35;
    localparam logic [7:0] C_RELOCATE  = 8'h85;
    localparam logic [7:0] C_STAT      = 8'h70;
    localparam logic [7:0] C_STAT_DIE  = 8'h78;
endpackage

// File: rtl/nand_bus_cycle.sv
// One NAND bus cycle per go: strobe low for a parameter count, then high.
// Assumes go is raised only while idle; a read samples dq_in on its last low clock.
module nand_bus_cycle
    import nand_seq_pkg::*;
#(
    parameter int T_WL = 2,
    parameter int T_WH = 2,
    parameter int T_RL = 3,
    parameter int T_RH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  cyc_kind_t  kind,
    input  logic [7:0] wbyte,
    input  logic [7:0] dq_in,
    output logic       idle,
    output logic       done,
    output logic [7:0] rbyte,
    output logic       we_n,
    output logic       re_n,
    output logic       cle,
    output logic       ale,
    output logic [7:0] dq_out,
    output logic       dq_oe
);
    localparam int TMAX = (T_WL > T_WH ? T_WL : T_WH) > (T_RL > T_RH ? T_RL : T_RH) ?
                          (T_WL > T_WH ? T_WL : T_WH) : (T_RL > T_RH ? T_RL : T_RH);
    localparam int CW = $clog2(TMAX + 1);

    typedef enum logic [1:0] {B_IDLE, B_LOW, B_HIGH} bst_t;
    bst_t          st;
    logic [CW-1:0] cnt;
    cyc_kind_t     kind_q;
    logic [7:0]    byte_q;
    logic          is_rd;
    logic [CW-1:0] lo_end, hi_end;

    assign is_rd  = (kind_q == CYC_DOUT);
    assign lo_end = is_rd ? CW'(T_RL - 1) : CW'(T_WL - 1);
    assign hi_end = is_rd ? CW'(T_RH - 1) : CW'(T_WH - 1);
    assign idle   = (st == B_IDLE);
    assign we_n   = !(st == B_LOW && !is_rd);
    assign re_n   = !(st == B_LOW && is_rd);
    assign cle    = !idle && kind_q == CYC_CMD;
    assign ale    = !idle && kind_q == CYC_ADDR;
    assign dq_oe  = !idle && !is_rd;
    assign dq_out = byte_q;

    // Purpose: step one cycle through low and high phases and capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= B_IDLE; cnt <= '0; kind_q <= CYC_CMD; byte_q <= '0; rbyte <= '0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                B_IDLE: if (go) begin
                    st <= B_LOW; cnt <= '0; kind_q <= kind; byte_q <= wbyte;
                end
                B_LOW: if (cnt == lo_end) begin
                    st <= B_HIGH; cnt <= '0;
                    if (is_rd) rbyte <= dq_in;
                end else cnt <= cnt + 1'b1;
                default: if (cnt == hi_end) begin
                    st <= B_IDLE; cnt <= '0; done <= 1'b1;
                end else cnt <= cnt + 1'b1;
            endcase
        end
    end

    assert_go_idle_R3: assert property (@(posedge clk) disable iff (!rst_n) go |-> st == B_IDLE);
    assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
endmodule

// File: rtl/nand_ready_wait.sv
// Waits a fixed settle time after a confirm, then polls ready/busy with a busy limit.
// Assumes limit is at least 1; ok and to are one-clock pulses.
module nand_ready_wait #(
    parameter int WB_CYC = 3,
    parameter int LIM_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rb_n,
    input  logic [LIM_W-1:0] limit,
    output logic             ok,
    output logic             to
);
    typedef enum logic [1:0] {W_IDLE, W_GUARD, W_POLL} wst_t;
    wst_t             st;
    logic [LIM_W-1:0] cnt;

    // Purpose: count the settle time, then count busy clocks until ready or limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= W_IDLE; cnt <= '0; ok <= 1'b0; to <= 1'b0;
        end else begin
            ok <= 1'b0; to <= 1'b0;
            case (st)
                W_IDLE: if (start) begin st <= W_GUARD; cnt <= '0; end
                W_GUARD: if (cnt == LIM_W'(WB_CYC - 1)) begin st <= W_POLL; cnt <= '0; end
                         else cnt <= cnt + 1'b1;
                default: if (rb_n) begin ok <= 1'b1; st <= W_IDLE; end
                         else if (cnt == limit - 1'b1) begin to <= 1'b1; st <= W_IDLE; end
                         else cnt <= cnt + 1'b1;
            endcase
        end
    end

    assert_ok_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n) ok |-> $past(rb_n));
    assert_to_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n) to |-> $past(!rb_n));
endmodule

// File: rtl/nand_prog_seq.sv
// Top sequencer: orders command, address, data, confirm, ready wait and status read.
// Assumes one request at a time; the status byte's bit 0 is the FAIL flag.
module nand_prog_seq
    import nand_seq_pkg::*;
#(
    parameter int NUM_DIES = 2,
    parameter int COL_W    = 16,
    parameter int ROW_W    = 24,
    parameter int LEN_W    = 12,
    parameter int LIM_W    = 16,
    parameter int T_WL     = 2,
    parameter int T_WH     = 2,
    parameter int T_RL     = 3,
    parameter int T_RH     = 2,
    parameter int WB_CYC   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [COL_W-1:0] req_col,
    input  logic [ROW_W-1:0] req_row,
    input  logic [ROW_W-1:0] req_dst_row,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_jump_en,
    input  logic [LEN_W-1:0] req_jump_at,
    input  logic [COL_W-1:0] req_jump_col,
    input  logic [7:0]       wr_data,
    output logic             data_take,
    input  logic [LIM_W-1:0] busy_limit,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             timeout,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb_n
);
    localparam int COL_CYC  = (COL_W + 7) / 8;
    localparam int ROW_CYC  = (ROW_W + 7) / 8;
    localparam int ADDR_CYC = COL_CYC + ROW_CYC;
    localparam int AI_W     = $clog2(ADDR_CYC + 1);
    localparam bit DIE_STAT = (NUM_DIES > 1);

    typedef enum logic [3:0] {T_IDLE, T_CMD, T_ADDR, T_DATA, T_JCMD, T_JADDR, T_CONF,
                              T_LAUNCH, T_WAIT, T_SCMD, T_SADDR, T_SREAD, T_SGET} tst_t;
    tst_t             st;
    op_t              op_q;
    logic [COL_W-1:0] col_q, jcol_q;
    logic [ROW_W-1:0] row_q, dst_q;
    logic [LEN_W-1:0] len_q, jat_q, bcnt;
    logic             jen_q, jumped, phase2;
    logic [AI_W-1:0]  aidx;

    logic             go, eng_idle, eng_done, rw_start, rw_ok, rw_to, jump_now, first_rd;
    cyc_kind_t        kind;
    logic [7:0]       wbyte, eng_rbyte;
    logic [ROW_W-1:0] row_sel;
    logic [ADDR_CYC*8-1:0] full_addr;
    logic [COL_CYC*8-1:0]  jaddr;

    assign first_rd  = (op_q == OP_MOVE) && !phase2;
    assign row_sel   = phase2 ? dst_q : row_q;
    assign full_addr = {(ROW_CYC*8)'(row_sel), (COL_CYC*8)'(col_q)};
    assign jaddr     = (COL_CYC*8)'(jcol_q);
    assign jump_now  = jen_q && !jumped && (bcnt == jat_q);
    assign busy      = (st != T_IDLE);
    assign nand_ce_n = !busy;
    assign rw_start  = (st == T_LAUNCH) && eng_idle;
    assign data_take = (st == T_DATA) && go;

    // Purpose: choose the next bus cycle to issue from the sequencer state.
    always_comb begin
        go = 1'b0; kind = CYC_CMD; wbyte = 8'h00;
        case (st)
            T_CMD:   begin go = eng_idle; wbyte = first_rd ? C_READ : (phase2 ? C_RELOCATE : C_LOAD); end
            T_ADDR:  begin go = eng_idle; kind = CYC_ADDR; wbyte = full_addr[aidx*8 +: 8]; end
            T_DATA:  begin go = eng_idle && !jump_now && bcnt != len_q; kind = CYC_DIN; wbyte = wr_data; end
            T_JCMD:  begin go = eng_idle; wbyte = C_RELOCATE; end
            T_JADDR: begin go = eng_idle; kind = CYC_ADDR; wbyte = jaddr[aidx*8 +: 8]; end
            T_CONF:  begin go = eng_idle;
                           wbyte = first_rd ? C_MOVE_RD : (op_q == OP_CACHE ? C_CACHE_CF : C_CONFIRM); end
            T_SCMD:  begin go = eng_idle; wbyte = DIE_STAT ? C_STAT_DIE : C_STAT; end
            T_SADDR: begin go = eng_idle; kind = CYC_ADDR; wbyte = full_addr[aidx*8 +: 8]; end
            T_SREAD: begin go = eng_idle; kind = CYC_DOUT; end
            default: ;
        endcase
    end

    // Purpose: advance the operation and record its result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= T_IDLE; op_q <= OP_PROG; col_q <= '0; jcol_q <= '0; row_q <= '0; dst_q <= '0;
            len_q <= '0; jat_q <= '0; bcnt <= '0; jen_q <= 1'b0; jumped <= 1'b0; phase2 <= 1'b0;
            aidx <= '0; done <= 1'b0; fail <= 1'b0; timeout <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                T_IDLE: if (req_valid) begin
                    op_q <= op_t'(req_op); col_q <= req_col; row_q <= req_row; dst_q <= req_dst_row;
                    len_q <= req_len; jen_q <= req_jump_en; jat_q <= req_jump_at; jcol_q <= req_jump_col;
                    bcnt <= '0; jumped <= 1'b0; phase2 <= 1'b0; aidx <= '0; fail <= 1'b0; timeout <= 1'b0;
                    st <= (op_t'(req_op) == OP_STAT) ? T_SCMD : T_CMD;
                end
                T_CMD: if (eng_idle) begin st <= T_ADDR; aidx <= '0; end
                T_ADDR: if (eng_idle) begin
                    if (aidx == AI_W'(ADDR_CYC - 1)) begin st <= first_rd ? T_CONF : T_DATA; bcnt <= '0; end
                    else aidx <= aidx + 1'b1;
                end
                T_DATA: if (eng_idle) begin
                    if (jump_now) st <= T_JCMD;
                    else if (bcnt == len_q) st <= T_CONF;
                    else bcnt <= bcnt + 1'b1;
                end
                T_JCMD: if (eng_idle) begin st <= T_JADDR; aidx <= '0; jumped <= 1'b1; end
                T_JADDR: if (eng_idle) begin
                    if (aidx == AI_W'(COL_CYC - 1)) st <= T_DATA;
                    else aidx <= aidx + 1'b1;
                end
                T_CONF:   if (eng_idle) st <= T_LAUNCH;
                T_LAUNCH: if (eng_idle) st <= T_WAIT;
                T_WAIT: if (rw_to) begin
                    timeout <= 1'b1; done <= 1'b1; st <= T_IDLE;
                end else if (rw_ok) begin
                    if (first_rd) begin phase2 <= 1'b1; st <= T_CMD; end
                    else st <= T_SCMD;
                end
                T_SCMD: if (eng_idle) begin
                    if (DIE_STAT) begin st <= T_SADDR; aidx <= AI_W'(COL_CYC); end
                    else st <= T_SREAD;
                end
                T_SADDR: if (eng_idle) begin
                    if (aidx == AI_W'(ADDR_CYC - 1)) st <= T_SREAD;
                    else aidx <= aidx + 1'b1;
                end
                T_SREAD: if (eng_idle) st <= T_SGET;
                T_SGET: if (eng_done) begin fail <= eng_rbyte[0]; done <= 1'b1; st <= T_IDLE; end
                default: st <= T_IDLE;
            endcase
        end
    end

    nand_bus_cycle #(.T_WL(T_WL), .T_WH(T_WH), .T_RL(T_RL), .T_RH(T_RH)) u_cycle (
        .clk(clk), .rst_n(rst_n), .go(go), .kind(kind), .wbyte(wbyte), .dq_in(nand_dq_in),
        .idle(eng_idle), .done(eng_done), .rbyte(eng_rbyte), .we_n(nand_we_n), .re_n(nand_re_n),
        .cle(nand_cle), .ale(nand_ale), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe));

    nand_ready_wait #(.WB_CYC(WB_CYC), .LIM_W(LIM_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .start(rw_start), .rb_n(nand_rb_n), .limit(busy_limit),
        .ok(rw_ok), .to(rw_to));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    assert_wait_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_WAIT) |-> (nand_we_n && nand_re_n));
    assert_timeout_nofail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout) |-> !fail);
    assert_ce_on_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
endmodule

// File: tb/test_nand_prog_seq.sv
module test_nand_prog_seq;
    localparam int T_WL = 2, T_RL = 3;

    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic        req_valid = 0, req_valid1 = 0, req_jump_en = 0;
    logic [1:0]  req_op = 0;
    logic [15:0] req_col = 0, req_jump_col = 0;
    logic [23:0] req_row = 0, req_dst_row = 0;
    logic [11:0] req_len = 0, req_jump_at = 0;
    logic [15:0] busy_limit = 16'd200;
    logic [7:0]  wr_data, stat_byte = 8'h40;
    logic        rb_n = 1;
    logic        data_take, busy, done, fail, timeout, ce_n, cle, ale, we_n, re_n, dq_oe;
    logic [7:0]  dq_out;
    logic        take1, busy1, done1, fail1, to1, ce1, cle1, ale1, we1, re1, oe1;
    logic [7:0]  dq1;

    int total = 0, bad = 0, dptr = 0, busy_cnt = 0, busy_time = 20, wl_run = 0, rl_run = 0;
    bit take_pend = 0, prev_we = 1, prev_we1 = 1, finished = 0;
    logic [9:0] cap_q[$], exp_q[$], cap1_q[$];

    assign wr_data = 8'h30 + 8'(dptr);

    nand_prog_seq i_nand_prog_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_col(req_col),
        .req_row(req_row), .req_dst_row(req_dst_row), .req_len(req_len), .req_jump_en(req_jump_en),
        .req_jump_at(req_jump_at), .req_jump_col(req_jump_col), .wr_data(wr_data), .data_take(data_take),
        .busy_limit(busy_limit), .busy(busy), .done(done), .fail(fail), .timeout(timeout),
        .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
        .nand_dq_out(dq_out), .nand_dq_oe(dq_oe), .nand_dq_in(stat_byte), .nand_rb_n(rb_n));

    nand_prog_seq #(.NUM_DIES(1)) i_nand_prog_seq_one (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid1), .req_op(req_op), .req_col(req_col),
        .req_row(req_row), .req_dst_row(req_dst_row), .req_len(req_len), .req_jump_en(req_jump_en),
        .req_jump_at(req_jump_at), .req_jump_col(req_jump_col), .wr_data(wr_data), .data_take(take1),
        .busy_limit(busy_limit), .busy(busy1), .done(done1), .fail(fail1), .timeout(to1),
        .nand_ce_n(ce1), .nand_cle(cle1), .nand_ale(ale1), .nand_we_n(we1), .nand_re_n(re1),
        .nand_dq_out(dq1), .nand_dq_oe(oe1), .nand_dq_in(8'h40), .nand_rb_n(1'b1));

    task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Flash model and per-clock reference checks, all on the falling edge.
    always @(negedge clk) begin
        if (take_pend) dptr++;
        take_pend = data_take;
        if (rst_n) begin
            check(!(cle && ale), "R3", "latch strobes together", {cle, ale}, 0);
            if (!rb_n) check(we_n && re_n, "R4", "strobe while busy", {we_n, re_n}, 3);
            if (!we_n) wl_run++;
            else if (wl_run != 0) begin check(wl_run == T_WL, "R3", "write low width", wl_run, T_WL); wl_run = 0; end
            if (!re_n) rl_run++;
            else if (rl_run != 0) begin check(rl_run == T_RL, "R3", "read low width", rl_run, T_RL); rl_run = 0; end
        end
        if (busy_cnt > 0) busy_cnt--;
        if (!prev_we && we_n) begin
            cap_q.push_back({cle, ale, dq_out});
            if (cle && (dq_out == 8'h10 || dq_out == 8'h15 || dq_out == 8'h35)) busy_cnt = busy_time;
        end
        if (!prev_we1 && we1) cap1_q.push_back({cle1, ale1, dq1});
        prev_we = we_n; prev_we1 = we1;
        rb_n = (busy_cnt == 0);
    end

    task automatic e_cmd(input logic [7:0] b);  exp_q.push_back({2'b10, b}); endtask
    task automatic e_adr(input logic [7:0] b);  exp_q.push_back({2'b01, b}); endtask
    task automatic e_dat(input int from, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back({2'b00, 8'(8'h30 + from + i)});
    endtask
    task automatic e_page(input logic [15:0] c, input logic [23:0] r);
        e_adr(c[7:0]); e_adr(c[15:8]); e_adr(r[7:0]); e_adr(r[15:8]); e_adr(r[23:16]);
    endtask
    task automatic e_stat(input logic [23:0] r);
        e_cmd(8'h78); e_adr(r[7:0]); e_adr(r[15:8]); e_adr(r[23:16]);
    endtask

    task automatic run_op(input logic [1:0] op, input logic [15:0] c, input logic [23:0] r, input logic [23:0] d,
                          input int len, input bit jen, input int jat, input logic [15:0] jc,
                          input logic [7:0] sb, input int bt);
        cap_q.delete(); dptr = 0; stat_byte = sb; busy_time = bt;
        @(negedge clk);
        req_op = op; req_col = c; req_row = r; req_dst_row = d; req_len = 12'(len);
        req_jump_en = jen; req_jump_at = 12'(jat); req_jump_col = jc; req_valid = 1;
        @(negedge clk); req_valid = 0;
        while (!done) @(negedge clk);
    endtask

    task automatic cmp_events(input string tag);
        int mism = -1;
        if (cap_q.size() == exp_q.size())
            for (int i = 0; i < cap_q.size(); i++) if (mism < 0 && cap_q[i] != exp_q[i]) mism = i;
        if (cap_q.size() != exp_q.size()) check(0, tag, "bus cycle count", cap_q.size(), exp_q.size());
        else if (mism >= 0) check(0, tag, $sformatf("bus cycle %0d", mism), cap_q[mism], exp_q[mism]);
        else check(1, tag, "bus cycles", 0, 0);
        exp_q.delete();
    endtask

    task automatic settle();
        while (!rb_n) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset levels
        check(ce_n && we_n && re_n && !cle && !ale && !busy && !done, "R1", "reset levels",
              {ce_n, we_n, re_n, cle, ale, busy, done}, 7'b1110000);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check(ce_n && we_n && re_n && !busy, "R1", "idle levels", {ce_n, we_n, re_n, busy}, 4'b1110);

        // R2, R4, R5: program, pass
        e_cmd(8'h80); e_page(16'h0123, 24'h045678); e_dat(0, 4); e_cmd(8'h10); e_stat(24'h045678);
        run_op(2'd0, 16'h0123, 24'h045678, 0, 4, 0, 0, 0, 8'h40, 20);
        cmp_events("R2");
        check(!fail && !timeout, "R5", "pass result", {fail, timeout}, 0);
        settle();

        // R5: program, status FAIL bit set
        e_cmd(8'h80); e_page(16'h0000, 24'h000101); e_dat(0, 2); e_cmd(8'h10); e_stat(24'h000101);
        run_op(2'd0, 16'h0000, 24'h000101, 0, 2, 0, 0, 0, 8'h41, 7);
        cmp_events("R4");
        check(fail == 1, "R5", "fail bit", fail, 1);
        settle();

        // R6: random data input after two bytes
        e_cmd(8'h80); e_page(16'h0123, 24'h0A0B0C); e_dat(0, 2); e_cmd(8'h85); e_adr(8'h00); e_adr(8'h02);
        e_dat(2, 2); e_cmd(8'h10); e_stat(24'h0A0B0C);
        run_op(2'd0, 16'h0123, 24'h0A0B0C, 0, 4, 1, 2, 16'h0200, 8'h40, 10);
        cmp_events("R6");
        settle();

        // R7: cache program confirm
        e_cmd(8'h80); e_page(16'h0010, 24'h112233); e_dat(0, 3); e_cmd(8'h15); e_stat(24'h112233);
        run_op(2'd1, 16'h0010, 24'h112233, 0, 3, 0, 0, 0, 8'h40, 5);
        cmp_events("R7");
        check(!fail, "R7", "cache result", fail, 0);
        settle();

        // R8: internal move
        e_cmd(8'h00); e_page(16'h0004, 24'h000200); e_cmd(8'h35);
        e_cmd(8'h85); e_page(16'h0004, 24'h000300); e_dat(0, 1); e_cmd(8'h10); e_stat(24'h000300);
        run_op(2'd2, 16'h0004, 24'h000200, 24'h000300, 1, 0, 0, 0, 8'h40, 15);
        cmp_events("R8");
        check(!fail && !timeout, "R8", "move result", {fail, timeout}, 0);
        settle();

        // R10: busy longer than the limit
        busy_limit = 16'd50;
        e_cmd(8'h80); e_page(16'h0000, 24'h000777); e_dat(0, 1); e_cmd(8'h10);
        run_op(2'd0, 16'h0000, 24'h000777, 0, 1, 0, 0, 0, 8'h40, 300);
        check(timeout == 1 && fail == 0, "R10", "timeout flags", {timeout, fail}, 2);
        repeat (10) @(negedge clk);
        cmp_events("R10");
        busy_limit = 16'd200;
        settle();

        // R11, R9: status poll on a multi-die target
        e_stat(24'hABCDEF);
        run_op(2'd3, 16'h0000, 24'hABCDEF, 0, 0, 0, 0, 0, 8'h41, 5);
        cmp_events("R11");
        check(fail == 1, "R11", "poll fail bit", fail, 1);
        settle();

        // R9: single-die status command
        cap1_q.delete();
        @(negedge clk); req_op = 2'd3; req_valid1 = 1;
        @(negedge clk); req_valid1 = 0;
        while (!done1) @(negedge clk);
        check(cap1_q.size() == 1, "R9", "single-die cycle count", cap1_q.size(), 1);
        if (cap1_q.size() > 0) check(cap1_q[0] == {2'b10, 8'h70}, "R9", "single-die command", cap1_q[0], {2'b10, 8'h70});
        check(!fail1, "R9", "single-die result", fail1, 0);

        @(negedge clk);
        check(!busy && ce_n && !done, "R1", "idle after ops", {busy, ce_n, done}, 3'b010);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule